// File: doc/BRIEF.md
# Size-list address range decoder

This block turns a bus address into a choice among several memory regions. The regions are not given as fixed base addresses. A parameter list of region sizes defines them instead. The first region starts at zero, and each later region begins on the word just past the end of the one before it. A base input is subtracted from the incoming address before any comparison is made, so the whole map can be moved anywhere in the address space without elaborating the block again.

The decoder is purely combinational. When both the enable and the select qualifier are high, it drives one select line for the region that owns the address, together with the address measured from that region's first word. An address that no region owns raises an out-of-range error code and puts the raw address on an error-address output. The error output can drive a peripheral bus slave-error response directly. Register storage, data muxing and bus handshaking are left to the logic around the block.

Top module: `span_decoder`

## Requirements
- R1: Region k covers relocated addresses from the sum of the sizes of regions 0..k-1 (inclusive) up to, but not including, that sum plus the size of region k. With enable and qualifier both high, an address in region k sets select bit k.
- R2: The relocated address is `addr_in - base_in` modulo 2^ADDR_W. Changing the base moves every region by the same amount.
- R3: If either `dec_en` or `sel_qual` is low, all select bits are 0, the offset is 0, the error code is 0 and the error address is 0.
- R4: At most one select bit is high at any time.
- R5: When select bit k is high, `rel_off` equals the relocated address minus the start of region k.
- R6: With enable and qualifier high and an address that falls in no region, `err_code` is 1, every select bit is 0, `rel_off` is 0 and `err_addr` equals `addr_in`, not the relocated address.
- R7: Whenever `err_code` is 0, `err_addr` is 0.
- R8: Error code encoding: 0 means no error and 1 means address out of range. With enable and qualifier high, exactly one of two things holds: one select bit is high, or the error code is 1.
- R9: Outputs depend only on the current inputs, with no clock and no latency.
- R10: Elaboration fails if any region size is zero, if the sizes sum to more than 2^ADDR_W, or if ADDR_W lies outside 2..62.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_in | input | ADDR_W | Incoming bus address |
| base_in | input | ADDR_W | Base subtracted before region comparison |
| dec_en | input | 1 | Decoder enable |
| sel_qual | input | 1 | Select qualifier, ANDed with the enable |
| region_sel | output | N_REG | One-hot region select |
| rel_off | output | ADDR_W | Address relative to the selected region's start |
| err_code | output | 1 | 0 = none, 1 = address out of range |
| err_addr | output | ADDR_W | Failing address when err_code is 1, else 0 |

## Verification
The bench builds the decoder with ADDR_W = 32 and the sizes 1024, 2048 and 4096. This gives three regions of different sizes, so a wrong start or end term for any one region shifts boundaries that the bench samples. The first word, last word and one-past-last word of every region are driven under a zero base and under a large nonzero base. An address below the base is also driven, which makes the subtraction wrap into the out-of-range area. The disabled and unqualified cases are driven with an address that would otherwise hit.

// File: rtl/span_decoder_pkg.sv
package span_decoder_pkg;

   localparam int ERR_W = 1;

   typedef enum logic [ERR_W-1:0] {
      DEC_OK        = 1'b0,
      DEC_OUT_RANGE = 1'b1
   } dec_err_e;

   localparam int MAX_ADDR_W = 62;
   localparam int MIN_ADDR_W = 2;

endpackage

// File: rtl/span_relocate.sv
module span_relocate #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] raw_addr,
   input  logic [ADDR_W-1:0] base_addr,
   output logic [ADDR_W-1:0] local_addr
);

   // Modulo subtraction: addresses below the base wrap high.
   always_comb begin
      local_addr = raw_addr - base_addr;
   end

endmodule

// File: rtl/span_match.sv
module span_match #(
   parameter int              ADDR_W        = 32,
   parameter int              N_REG         = 3,
   parameter longint unsigned SIZES [N_REG] = '{default: 64'd1},
   parameter int              IDX           = 0
) (
   input  logic [ADDR_W-1:0] local_addr,
   input  logic              active,
   output logic              hit,
   output logic [ADDR_W-1:0] start_addr
);

   function automatic longint unsigned bound_upto(input int k);
      longint unsigned s;
      s = 64'd0;
      for (int j = 0; j < k; j++) s += SIZES[j];
      return s;
   endfunction

   localparam longint unsigned LO   = bound_upto(IDX);
   localparam longint unsigned HI   = bound_upto(IDX + 1);
   localparam logic [ADDR_W:0] LO_V = LO[ADDR_W:0];
   localparam logic [ADDR_W:0] HI_V = HI[ADDR_W:0];

   logic [ADDR_W:0] wide_addr;

   always_comb begin
      wide_addr  = {1'b0, local_addr};
      hit        = active && (wide_addr >= LO_V) && (wide_addr < HI_V);
      start_addr = LO_V[ADDR_W-1:0];
   end

endmodule

// File: rtl/span_output.sv
module span_output
   import span_decoder_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int N_REG  = 3
) (
   input  logic [N_REG-1:0]             hit_vec,
   input  logic [N_REG-1:0][ADDR_W-1:0] start_vec,
   input  logic [ADDR_W-1:0]            local_addr,
   input  logic [ADDR_W-1:0]            raw_addr,
   input  logic                         active,
   output logic [N_REG-1:0]             sel_out,
   output logic [ADDR_W-1:0]            off_out,
   output dec_err_e                     err_out,
   output logic [ADDR_W-1:0]            err_addr_out
);

   logic any_hit;

   always_comb begin
      any_hit = |hit_vec;
      sel_out = hit_vec;
      off_out = '0;
      for (int i = 0; i < N_REG; i++) begin
         if (hit_vec[i]) off_out = off_out | (local_addr - start_vec[i]);
      end
      if (active && !any_hit) begin
         err_out      = DEC_OUT_RANGE;
         err_addr_out = raw_addr;
      end else begin
         err_out      = DEC_OK;
         err_addr_out = '0;
      end
   end

endmodule

// File: rtl/span_decoder.sv
module span_decoder
   import span_decoder_pkg::*;
#(
   parameter int              ADDR_W        = 32,
   parameter int              N_REG         = 3,
   parameter longint unsigned SIZES [N_REG] = '{64'd1024, 64'd2048, 64'd4096}
) (
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [ADDR_W-1:0] base_in,
   input  logic              dec_en,
   input  logic              sel_qual,
   output logic [N_REG-1:0]  region_sel,
   output logic [ADDR_W-1:0] rel_off,
   output logic [ERR_W-1:0]  err_code,
   output logic [ADDR_W-1:0] err_addr
);

   function automatic longint unsigned span_total();
      longint unsigned s;
      s = 64'd0;
      for (int j = 0; j < N_REG; j++) s += SIZES[j];
      return s;
   endfunction

   function automatic bit any_zero();
      bit z;
      z = 1'b0;
      for (int j = 0; j < N_REG; j++) if (SIZES[j] == 64'd0) z = 1'b1;
      return z;
   endfunction

   localparam longint unsigned TOTAL = span_total();

   // R10: elaboration-time parameter checks
   if (ADDR_W < MIN_ADDR_W || ADDR_W > MAX_ADDR_W) begin : g_bad_width
      $error("span_decoder: ADDR_W out of supported range");
   end
   if (N_REG < 1) begin : g_bad_count
      $error("span_decoder: at least one region required");
   end
   if (any_zero()) begin : g_bad_size
      $error("span_decoder: zero-sized region");
   end
   if (ADDR_W <= MAX_ADDR_W && TOTAL > (64'd1 << ADDR_W)) begin : g_bad_total
      $error("span_decoder: region sizes exceed address space");
   end

   logic                         active;
   logic [ADDR_W-1:0]            local_addr;
   logic [N_REG-1:0]             hit_vec;
   logic [N_REG-1:0][ADDR_W-1:0] start_vec;
   dec_err_e                     err_e;

   always_comb active = dec_en && sel_qual;

   span_relocate #(.ADDR_W(ADDR_W)) u_reloc (
      .raw_addr   (addr_in),
      .base_addr  (base_in),
      .local_addr (local_addr)
   );

   for (genvar g = 0; g < N_REG; g++) begin : g_region
      span_match #(
         .ADDR_W (ADDR_W),
         .N_REG  (N_REG),
         .SIZES  (SIZES),
         .IDX    (g)
      ) u_match (
         .local_addr (local_addr),
         .active     (active),
         .hit        (hit_vec[g]),
         .start_addr (start_vec[g])
      );
   end

   span_output #(.ADDR_W(ADDR_W), .N_REG(N_REG)) u_out (
      .hit_vec      (hit_vec),
      .start_vec    (start_vec),
      .local_addr   (local_addr),
      .raw_addr     (addr_in),
      .active       (active),
      .sel_out      (region_sel),
      .off_out      (rel_off),
      .err_out      (err_e),
      .err_addr_out (err_addr)
   );

   always_comb err_code = err_e;

endmodule

// File: rtl/span_decoder_chk.sv
module span_decoder_chk #(
   parameter int ADDR_W = 32,
   parameter int N_REG  = 3
) (
   input logic [ADDR_W-1:0] addr_in,
   input logic              dec_en,
   input logic              sel_qual,
   input logic [N_REG-1:0]  region_sel,
   input logic [ADDR_W-1:0] rel_off,
   input logic [0:0]        err_code,
   input logic [ADDR_W-1:0] err_addr
);

   always_comb begin
      // R4
      sel_onehot_chk: assert ($onehot0(region_sel));
      // R3
      gate_off_chk: assert ((dec_en && sel_qual) || (region_sel == '0 && err_code == 1'b0 && rel_off == '0));
      // R6
      miss_clean_chk: assert (err_code == 1'b0 || (region_sel == '0 && rel_off == '0 && err_addr == addr_in));
      // R7
      quiet_addr_chk: assert (err_code == 1'b1 || err_addr == '0);
      // R8
      hit_xor_err_chk: assert (!(dec_en && sel_qual) || ((region_sel != '0) != (err_code == 1'b1)));
   end

endmodule

bind span_decoder span_decoder_chk #(.ADDR_W(ADDR_W), .N_REG(N_REG)) u_chk (
   .addr_in    (addr_in),
   .dec_en     (dec_en),
   .sel_qual   (sel_qual),
   .region_sel (region_sel),
   .rel_off    (rel_off),
   .err_code   (err_code),
   .err_addr   (err_addr)
);

// File: tb/tb_span_decoder.sv
module tb_span_decoder;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int NR = 3;
   localparam longint unsigned SZ [NR] = '{64'd1024, 64'd2048, 64'd4096};
   localparam longint unsigned MASK = (64'd1 << AW) - 64'd1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [AW-1:0] addr_in = '0, base_in = '0;
   logic dec_en = 1'b0, sel_qual = 1'b0;
   logic [NR-1:0] region_sel;
   logic [AW-1:0] rel_off, err_addr;
   logic [0:0]    err_code;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   span_decoder #(.ADDR_W(AW), .N_REG(NR), .SIZES(SZ)) dut (
      .addr_in (addr_in), .base_in (base_in), .dec_en (dec_en), .sel_qual (sel_qual),
      .region_sel (region_sel), .rel_off (rel_off), .err_code (err_code), .err_addr (err_addr)
   );

   // Reference model: walk the size list with integer arithmetic.
   task automatic model(input longint unsigned a, input longint unsigned b,
                        input bit en, input bit q,
                        output longint unsigned e_sel, output longint unsigned e_off,
                        output longint unsigned e_err, output longint unsigned e_ea);
      longint unsigned loc, lo;
      e_sel = 0; e_off = 0; e_err = 0; e_ea = 0;
      if (!(en && q)) return;
      loc = (a - b) & MASK;
      lo = 0;
      for (int k = 0; k < NR; k++) begin
         if (loc >= lo && loc < lo + SZ[k]) begin
            e_sel = 64'd1 << k;
            e_off = loc - lo;
         end
         lo += SZ[k];
      end
      if (e_sel == 0) begin
         e_err = 1;
         e_ea  = a;
      end
   endtask

   task automatic apply_and_check(input longint unsigned a, input longint unsigned b,
                                  input bit en, input bit q, input string req);
      longint unsigned es, eo, ee, ea;
      @(posedge clk);
      addr_in  = a[AW-1:0];
      base_in  = b[AW-1:0];
      dec_en   = en;
      sel_qual = q;
      model(a, b, en, q, es, eo, ee, ea);
      @(negedge clk);
      checks++;
      if (64'(region_sel) != es || 64'(rel_off) != eo || 64'(err_code) != ee || 64'(err_addr) != ea) begin
         errors++;
         $display("FAIL %s addr=%h base=%h: sel=%b off=%h err=%0d eaddr=%h, expected sel=%b off=%h err=%0d eaddr=%h",
                  req, a, b, region_sel, rel_off, err_code, err_addr, es[NR-1:0], eo, ee, ea);
      end
   endtask

   initial begin
      longint unsigned lo;
      longint unsigned bases [2];
      bases[0] = 64'd0;
      bases[1] = 64'h1000_0000;
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      // R3: idle state with decoder disabled
      apply_and_check(64'd0, 64'd0, 1'b0, 1'b0, "R3");
      for (int bi = 0; bi < 2; bi++) begin
         lo = 0;
         for (int k = 0; k < NR; k++) begin
            // R1 R5: first and last word of region k; R2 when base is nonzero
            apply_and_check(bases[bi] + lo, bases[bi], 1'b1, 1'b1, "R1/R5");
            apply_and_check(bases[bi] + lo + SZ[k] - 1, bases[bi], 1'b1, 1'b1, "R1/R5");
            // R1 R4: one past the end moves to the next region or misses (R6)
            apply_and_check(bases[bi] + lo + SZ[k], bases[bi], 1'b1, 1'b1, "R1/R4");
            lo += SZ[k];
         end
         // R6: far beyond the span
         apply_and_check(bases[bi] + 64'h0100_0000, bases[bi], 1'b1, 1'b1, "R6");
         // R2: mid-region address under this base
         apply_and_check(bases[bi] + 64'd1500, bases[bi], 1'b1, 1'b1, "R2");
      end
      // R2 R6: address below the base wraps out of range
      apply_and_check(64'h0FFF_FFFF, 64'h1000_0000, 1'b1, 1'b1, "R2/R6");
      // R3: enable or qualifier alone blocks a hit
      apply_and_check(64'd10, 64'd0, 1'b1, 1'b0, "R3");
      apply_and_check(64'd10, 64'd0, 1'b0, 1'b1, "R3");
      apply_and_check(64'hFFFF_0000, 64'd0, 1'b0, 1'b1, "R3/R7");
      // R7 R8: hit leaves error address zero; R9: immediate response back-to-back
      apply_and_check(64'd2000, 64'd0, 1'b1, 1'b1, "R7/R8");
      apply_and_check(64'd9000, 64'd0, 1'b1, 1'b1, "R8/R9");
      apply_and_check(64'd7167, 64'd0, 1'b1, 1'b1, "R9");
      // R10 is covered by elaboration of the default size list.
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule